// File: doc/BRIEF.md
# Atomic Memory Operation Unit

This unit carries out the atomic read-modify-write instructions of a 64-bit packet-filter style instruction set on a small word memory that it owns. A decoded instruction word arrives with a request strobe. The unit reads its base and source operands, and register 0, through combinational register-file read ports. It then reads the addressed word, combines that word with the operand, writes the memory and returns the previous value to the register file. The supported operations are add, OR, AND, XOR, exchange and compare-and-swap, each in doubleword and word sizes.

A second requester reaches the same memory through a simple word port. That port is locked out while an atomic operation runs, so the read and the write of each operation cannot be split by another access. Encodings that are not supported raise an illegal pulse. Accesses that are not aligned to their size raise a fault pulse. In both cases nothing changes.

Top module: `amo_unit`

## Requirements
- R1: After reset, busy_o, illegal_o, fault_o and rf_we_o are low and every memory word reads as zero.
- R2: With BIG_ENDIAN=0, insn_i bits [7:0] are the opcode, bits [11:8] the base register, bits [15:12] the source register, bits [31:16] a signed offset and bits [63:32] the operation selector. Opcode 0xDB selects a 64-bit access and 0xC3 a 32-bit access. With BIG_ENDIAN=1 the two register nibbles swap places and the offset and selector bytes are reversed.
- R3: The byte address is the base register plus the sign-extended offset. Address bits [AW+2:3] pick the memory word and higher bits are ignored. For a 32-bit access, address bit 2 picks the upper (1) or lower (0) half of the word.
- R4: Selectors 0x00, 0x40, 0x50 and 0xA0 store old+src, old|src, old&src and old^src to memory with no register writeback. Setting selector bit 0 (0x01, 0x41, 0x51, 0xA1) also writes the old memory value into the source register.
- R5: Selector 0xE1 stores the source register to memory and writes the old memory value into the source register.
- R6: Selector 0xF1 compares register 0 with the memory value and stores the source register only when they are equal. Whether or not they matched, the old memory value is written to register 0.
- R7: A 32-bit access uses the low 32 bits of the source register and of register 0. It leaves the other half of the memory word unchanged and writes back the old half zero-extended to 64 bits.
- R8: An opcode other than 0xDB or 0xC3, a selector with any of bits [31:8] set, or any selector value not listed in R4 to R6 (0xE0 and 0xF0 included) gives a one-cycle illegal_o pulse in the cycle after acceptance. It makes no memory or register change.
- R9: A legal operation whose address is not 8-byte aligned (64-bit) or 4-byte aligned (32-bit) gives a one-cycle fault_o pulse in the cycle after acceptance and makes no access. An illegal encoding reports only illegal_o.
- R10: A request is accepted only while busy_o is low. An accepted legal aligned operation holds busy_o high for exactly the two cycles after acceptance. Its register writeback is presented in the second of those cycles.
- R11: The second port is granted only when the unit is idle and req_i is low. A granted write stores p2_wdata_i to word p2_addr_i, and a granted read returns the word on p2_rdata_o one cycle later. The port is never granted while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Instruction request |
| insn_i | input | 64 | Instruction word |
| rf_dst_addr_o | output | 4 | Base register read address |
| rf_src_addr_o | output | 4 | Source register read address |
| rf_dst_data_i | input | 64 | Base register value |
| rf_src_data_i | input | 64 | Source register value |
| rf_r0_data_i | input | 64 | Register 0 value |
| rf_we_o | output | 1 | Register writeback enable |
| rf_waddr_o | output | 4 | Writeback register |
| rf_wdata_o | output | 64 | Writeback value |
| busy_o | output | 1 | Atomic operation in progress |
| illegal_o | output | 1 | Illegal encoding pulse |
| fault_o | output | 1 | Misaligned address pulse |
| p2_req_i | input | 1 | Second port request |
| p2_we_i | input | 1 | Second port write |
| p2_addr_i | input | AW | Second port word index |
| p2_wdata_i | input | 64 | Second port write data |
| p2_gnt_o | output | 1 | Second port grant |
| p2_rdata_o | output | 64 | Second port read data |

## Verification
The assertions assume three things about the inputs. Register read data is stable and valid in the cycle of acceptance. req_i is raised only while the unit is idle. Second-port requests may arrive at any time and simply wait for a grant. The stimulus meets these by issuing each instruction for a single cycle and then waiting out the full operation before the next request. It drives the second port only in the idle gaps, except for deliberate probes during busy and during a pending request. Random operands keep base and source registers distinct and vary the upper address bits, the offset sign and the half-word lane. About half of the compare-and-swap operations are forced to match.

// File: rtl/amo_pkg.sv
package amo_pkg;
  localparam int XLEN = 64;
  localparam logic [7:0] OPC_DWORD = 8'hDB;
  localparam logic [7:0] OPC_WORD  = 8'hC3;

  typedef enum logic [2:0] {
    OP_ADD, OP_OR, OP_AND, OP_XOR, OP_XCHG, OP_CAS
  } amo_op_e;

  typedef struct packed {
    amo_op_e     op;
    logic        fetch;
    logic        word32;
    logic [3:0]  dst;
    logic [3:0]  src;
    logic [15:0] off;
  } amo_insn_t;
endpackage

// File: rtl/amo_decode.sv
module amo_decode import amo_pkg::*; #(
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic [63:0] insn_i,
  output amo_insn_t   dec_o,
  output logic        illegal_o
);
  logic [7:0]  opc;
  logic [3:0]  dst, src;
  logic [15:0] off;
  logic [31:0] imm;

  assign opc = insn_i[7:0];

  generate
    if (BIG_ENDIAN) begin : g_be
      assign dst = insn_i[15:12];
      assign src = insn_i[11:8];
      assign off = {insn_i[23:16], insn_i[31:24]};
      assign imm = {insn_i[39:32], insn_i[47:40], insn_i[55:48], insn_i[63:56]};
    end else begin : g_le
      assign dst = insn_i[11:8];
      assign src = insn_i[15:12];
      assign off = insn_i[31:16];
      assign imm = insn_i[63:32];
    end
  endgenerate

  logic    sel_ok;
  amo_op_e op;

  always_comb begin
    sel_ok = 1'b1;
    op     = OP_ADD;
    unique case (imm[7:0])
      8'h00, 8'h01: op = OP_ADD;
      8'h40, 8'h41: op = OP_OR;
      8'h50, 8'h51: op = OP_AND;
      8'hA0, 8'hA1: op = OP_XOR;
      8'hE1:        op = OP_XCHG;
      8'hF1:        op = OP_CAS;
      default:      sel_ok = 1'b0;
    endcase
  end

  always_comb begin
    dec_o.op     = op;
    dec_o.fetch  = imm[0];
    dec_o.word32 = (opc == OPC_WORD);
    dec_o.dst    = dst;
    dec_o.src    = src;
    dec_o.off    = off;
  end

  assign illegal_o = !sel_ok || (imm[31:8] != '0) ||
                     ((opc != OPC_DWORD) && (opc != OPC_WORD));
endmodule

// File: rtl/amo_alu.sv
module amo_alu import amo_pkg::*; (
  input  amo_op_e          op_i,
  input  logic             word32_i,
  input  logic             hi_i,
  input  logic [XLEN-1:0]  old_i,
  input  logic [XLEN-1:0]  src_i,
  input  logic [XLEN-1:0]  cmp_i,
  output logic [XLEN-1:0]  new_o,
  output logic [XLEN-1:0]  wb_o,
  output logic             mem_we_o
);
  localparam int HW = XLEN / 2;

  logic [XLEN-1:0] old_l, src_l, cmp_l, res_l;

  always_comb begin
    if (word32_i) begin
      old_l = {{HW{1'b0}}, (hi_i ? old_i[XLEN-1:HW] : old_i[HW-1:0])};
      src_l = {{HW{1'b0}}, src_i[HW-1:0]};
      cmp_l = {{HW{1'b0}}, cmp_i[HW-1:0]};
    end else begin
      old_l = old_i;
      src_l = src_i;
      cmp_l = cmp_i;
    end

    mem_we_o = 1'b1;
    unique case (op_i)
      OP_ADD:  res_l = old_l + src_l;
      OP_OR:   res_l = old_l | src_l;
      OP_AND:  res_l = old_l & src_l;
      OP_XOR:  res_l = old_l ^ src_l;
      OP_XCHG: res_l = src_l;
      OP_CAS: begin
        res_l    = src_l;
        mem_we_o = (old_l == cmp_l);
      end
      default: res_l = old_l;
    endcase

    if (!word32_i)  new_o = res_l;
    else if (hi_i)  new_o = {res_l[HW-1:0], old_i[HW-1:0]};
    else            new_o = {old_i[XLEN-1:HW], res_l[HW-1:0]};

    wb_o = old_l;
  end
endmodule

// File: rtl/amo_mem.sv
module amo_mem #(
  parameter int WORDS = 16,
  parameter int DW    = 64,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          a_re_i,
  input  logic          a_we_i,
  input  logic [AW-1:0] a_addr_i,
  input  logic [DW-1:0] a_wdata_i,
  output logic [DW-1:0] a_rdata_o,
  input  logic          b_en_i,
  input  logic          b_we_i,
  input  logic [AW-1:0] b_addr_i,
  input  logic [DW-1:0] b_wdata_i,
  output logic [DW-1:0] b_rdata_o
);
  logic [DW-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
      a_rdata_o <= '0;
      b_rdata_o <= '0;
    end else begin
      if (a_re_i) a_rdata_o <= mem_q[a_addr_i];
      if (a_we_i) mem_q[a_addr_i] <= a_wdata_i;
      if (b_en_i && b_we_i) mem_q[b_addr_i] <= b_wdata_i;
      if (b_en_i && !b_we_i) b_rdata_o <= mem_q[b_addr_i];
    end
  end

  AST_ONE_WRITER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((a_we_i || a_re_i) && b_en_i)); // R11
endmodule

// File: rtl/amo_unit.sv
module amo_unit import amo_pkg::*; #(
  parameter int MEM_WORDS  = 16,
  parameter bit BIG_ENDIAN = 1'b0,
  localparam int AW        = $clog2(MEM_WORDS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic [63:0]     insn_i,
  output logic [3:0]      rf_dst_addr_o,
  output logic [3:0]      rf_src_addr_o,
  input  logic [63:0]     rf_dst_data_i,
  input  logic [63:0]     rf_src_data_i,
  input  logic [63:0]     rf_r0_data_i,
  output logic            rf_we_o,
  output logic [3:0]      rf_waddr_o,
  output logic [63:0]     rf_wdata_o,
  output logic            busy_o,
  output logic            illegal_o,
  output logic            fault_o,
  input  logic            p2_req_i,
  input  logic            p2_we_i,
  input  logic [AW-1:0]   p2_addr_i,
  input  logic [63:0]     p2_wdata_i,
  output logic            p2_gnt_o,
  output logic [63:0]     p2_rdata_o
);
  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE} state_e;

  state_e    state_q;
  amo_insn_t dec;
  logic      dec_ill;

  amo_decode #(.BIG_ENDIAN(BIG_ENDIAN)) u_dec (
    .insn_i   (insn_i),
    .dec_o    (dec),
    .illegal_o(dec_ill)
  );

  assign rf_dst_addr_o = dec.dst;
  assign rf_src_addr_o = dec.src;

  logic [63:0] ea;
  logic        misal, try_acc, start;
  assign ea      = rf_dst_data_i + {{48{dec.off[15]}}, dec.off};
  assign misal   = dec.word32 ? (ea[1:0] != 2'b00) : (ea[2:0] != 3'b000);
  assign try_acc = req_i && (state_q == S_IDLE);
  assign start   = try_acc && !dec_ill && !misal;

  logic unused_ea_hi;
  assign unused_ea_hi = ^ea[63:AW+3];

  amo_op_e       op_q;
  logic          fetch_q, w32_q, hi_q;
  logic [3:0]    src_idx_q;
  logic [AW-1:0] widx_q;
  logic [63:0]   src_q, r0_q;
  logic          ill_q, flt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      op_q      <= OP_ADD;
      fetch_q   <= 1'b0;
      w32_q     <= 1'b0;
      hi_q      <= 1'b0;
      src_idx_q <= '0;
      widx_q    <= '0;
      src_q     <= '0;
      r0_q      <= '0;
      ill_q     <= 1'b0;
      flt_q     <= 1'b0;
    end else begin
      ill_q <= try_acc && dec_ill;
      flt_q <= try_acc && !dec_ill && misal;
      unique case (state_q)
        S_IDLE: if (start) begin
          state_q   <= S_READ;
          op_q      <= dec.op;
          fetch_q   <= dec.fetch;
          w32_q     <= dec.word32;
          hi_q      <= ea[2];
          src_idx_q <= dec.src;
          widx_q    <= ea[AW+2:3];
          src_q     <= rf_src_data_i;
          r0_q      <= rf_r0_data_i;
        end
        S_READ:  state_q <= S_WRITE;
        S_WRITE: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  logic [63:0] mem_old, alu_new, alu_wb;
  logic        alu_we;

  amo_alu u_alu (
    .op_i    (op_q),
    .word32_i(w32_q),
    .hi_i    (hi_q),
    .old_i   (mem_old),
    .src_i   (src_q),
    .cmp_i   (r0_q),
    .new_o   (alu_new),
    .wb_o    (alu_wb),
    .mem_we_o(alu_we)
  );

  assign p2_gnt_o = p2_req_i && (state_q == S_IDLE) && !req_i;

  amo_mem #(.WORDS(MEM_WORDS), .DW(64)) u_mem (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .a_re_i   (state_q == S_READ),
    .a_we_i   ((state_q == S_WRITE) && alu_we),
    .a_addr_i (widx_q),
    .a_wdata_i(alu_new),
    .a_rdata_o(mem_old),
    .b_en_i   (p2_gnt_o),
    .b_we_i   (p2_we_i),
    .b_addr_i (p2_addr_i),
    .b_wdata_i(p2_wdata_i),
    .b_rdata_o(p2_rdata_o)
  );

  assign busy_o     = (state_q != S_IDLE);
  assign rf_we_o    = (state_q == S_WRITE) && fetch_q;
  assign rf_waddr_o = (op_q == OP_CAS) ? 4'd0 : src_idx_q;
  assign rf_wdata_o = alu_wb;
  assign illegal_o  = ill_q;
  assign fault_o    = flt_q;

  AST_P2_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !p2_gnt_o); // R11
  AST_ERR_NO_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (illegal_o || fault_o) |-> !busy_o); // R8
  AST_PULSE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(illegal_o && fault_o)); // R9
  AST_BUSY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |=> busy_o); // R10
  AST_BUSY_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |=> !busy_o); // R10
  AST_WB_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> (busy_o && $past(busy_o))); // R10
endmodule

// File: tb/tb_amo_unit.sv
module tb_amo_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        req = 1'b0;
  logic [63:0] insn = '0;
  logic [3:0]  dst_a, src_a, waddr;
  logic [63:0] wdata, p2_rdata;
  logic        rf_we, busy, ill, flt, p2_gnt;
  logic        p2_req = 1'b0, p2_we = 1'b0;
  logic [3:0]  p2_addr = '0;
  logic [63:0] p2_wdata = '0;
  logic [63:0] regs [16];
  logic [63:0] mem_m [16];

  amo_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .insn_i(insn),
    .rf_dst_addr_o(dst_a), .rf_src_addr_o(src_a),
    .rf_dst_data_i(regs[dst_a]), .rf_src_data_i(regs[src_a]), .rf_r0_data_i(regs[0]),
    .rf_we_o(rf_we), .rf_waddr_o(waddr), .rf_wdata_o(wdata),
    .busy_o(busy), .illegal_o(ill), .fault_o(flt),
    .p2_req_i(p2_req), .p2_we_i(p2_we), .p2_addr_i(p2_addr), .p2_wdata_i(p2_wdata),
    .p2_gnt_o(p2_gnt), .p2_rdata_o(p2_rdata)
  );

  always @(posedge clk) if (rf_we) regs[waddr] <= wdata;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] enc(input logic [7:0] opc, input logic [3:0] d,
                                      input logic [3:0] s, input logic [15:0] off,
                                      input logic [31:0] imm);
    return {imm, off, s, d, opc};
  endfunction

  function automatic bit sel_legal(input logic [31:0] imm);
    if (imm[31:8] != 0) return 1'b0;
    case (imm[7:0])
      8'h00, 8'h01, 8'h40, 8'h41, 8'h50, 8'h51, 8'hA0, 8'hA1, 8'hE1, 8'hF1: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] opc, input logic [31:0] imm);
    if (opc == 8'hC3) return "R7";
    if (imm[7:0] == 8'hF1) return "R6";
    if (imm[7:0] == 8'hE1) return "R5";
    return "R4";
  endfunction

  task automatic p2_write(input logic [3:0] a, input logic [63:0] v);
    @(negedge clk); p2_req = 1; p2_we = 1; p2_addr = a; p2_wdata = v;
    @(negedge clk); p2_req = 0; p2_we = 0;
  endtask

  task automatic p2_read(input logic [3:0] a, output logic [63:0] v);
    @(negedge clk); p2_req = 1; p2_we = 0; p2_addr = a;
    @(negedge clk); p2_req = 0; v = p2_rdata;
  endtask

  function automatic logic [63:0] ea_of(input logic [3:0] d, input logic [15:0] off);
    return regs[d] + {{48{off[15]}}, off};
  endfunction

  task automatic do_amo(input logic [7:0] opc, input logic [3:0] d, input logic [3:0] s,
                        input logic [15:0] off, input logic [31:0] imm);
    logic [63:0] ea, old, lane, sl, cl, res, nw, expwb, rd;
    logic [3:0]  idx, wreg;
    bit w32, hi, bad, mis, wr, wbe;
    string t;
    ea  = ea_of(d, off);
    idx = ea[6:3];
    hi  = ea[2];
    w32 = (opc == 8'hC3);
    bad = !sel_legal(imm) || (opc != 8'hDB && opc != 8'hC3);
    mis = w32 ? (ea[1:0] != 0) : (ea[2:0] != 0);
    t   = tag_of(opc, imm);
    old = mem_m[idx];
    lane = w32 ? {32'b0, (hi ? old[63:32] : old[31:0])} : old;
    sl   = w32 ? {32'b0, regs[s][31:0]} : regs[s];
    cl   = w32 ? {32'b0, regs[0][31:0]} : regs[0];
    wr = 1'b1;
    case (imm[7:0])
      8'h00, 8'h01: res = lane + sl;
      8'h40, 8'h41: res = lane | sl;
      8'h50, 8'h51: res = lane & sl;
      8'hA0, 8'hA1: res = lane ^ sl;
      8'hF1: begin res = sl; wr = (lane == cl); end
      default: res = sl;
    endcase
    if (!wr) nw = old;
    else if (!w32) nw = res;
    else nw = hi ? {res[31:0], old[31:0]} : {old[63:32], res[31:0]};
    wbe   = imm[0];
    wreg  = (imm[7:0] == 8'hF1) ? 4'd0 : s;
    expwb = lane;

    @(negedge clk); insn = enc(opc, d, s, off, imm); req = 1;
    @(negedge clk); req = 0;
    if (bad) begin
      chk(ill === 1'b1 && flt === 1'b0, "R8 illegal pulse", {62'b0, ill, flt}, 64'h2);
      @(negedge clk);
      chk(ill === 1'b0 && busy === 1'b0 && rf_we === 1'b0, "R8 no effect", {61'b0, ill, busy, rf_we}, 0);
    end else if (mis) begin
      chk(flt === 1'b1 && ill === 1'b0, "R9 fault pulse", {62'b0, ill, flt}, 64'h1);
      @(negedge clk);
      chk(flt === 1'b0 && busy === 1'b0 && rf_we === 1'b0, "R9 no access", {61'b0, flt, busy, rf_we}, 0);
    end else begin
      chk(busy === 1'b1 && ill === 1'b0 && flt === 1'b0, "R10 busy first", {63'b0, busy}, 1);
      p2_req = 1; #1;
      chk(p2_gnt === 1'b0, "R11 locked", {63'b0, p2_gnt}, 0);
      p2_req = 0;
      @(negedge clk);
      chk(busy === 1'b1, "R10 busy second", {63'b0, busy}, 1);
      chk(rf_we === wbe, {t, " wb enable"}, {63'b0, rf_we}, {63'b0, wbe});
      if (wbe) begin
        chk(waddr === wreg, {t, " wb reg"}, {60'b0, waddr}, {60'b0, wreg});
        chk(wdata === expwb, {t, " wb value"}, wdata, expwb);
      end
      @(negedge clk);
      chk(busy === 1'b0, "R10 idle after two", {63'b0, busy}, 0);
      if (wbe) chk(regs[wreg] === expwb, {t, " reg file"}, regs[wreg], expwb);
      mem_m[idx] = nw;
    end
    p2_read(idx, rd);
    chk(rd === mem_m[idx], {t, " R3 memory word"}, rd, mem_m[idx]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=%h exp=%h", 64'd0, 64'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    logic [31:0] legal [10];
    void'($urandom(32'd4711));
    legal = '{32'h00, 32'h01, 32'h40, 32'h41, 32'h50, 32'h51, 32'hA0, 32'hA1, 32'hE1, 32'hF1};
    for (int i = 0; i < 16; i++) begin regs[i] = '0; mem_m[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk({busy, ill, flt, rf_we} === 4'b0, "R1 reset outputs", {60'b0, busy, ill, flt, rf_we}, 0);
    p2_read(4'd5, v);
    chk(v === 64'd0, "R1 memory cleared", v, 0);

    for (int i = 0; i < 16; i++) begin
      mem_m[i] = {$urandom, $urandom};
      p2_write(i[3:0], mem_m[i]);
    end
    p2_read(4'd9, v);
    chk(v === mem_m[9], "R11 port write/read", v, mem_m[9]);

    // R11: no grant while a unit request is pending
    @(negedge clk); insn = enc(8'h00, 1, 2, 0, 32'h33); req = 1; p2_req = 1; #1;
    chk(p2_gnt === 1'b0, "R11 yield to request", {63'b0, p2_gnt}, 0);
    @(negedge clk); req = 0; p2_req = 0;

    // directed: R6 compare-and-swap match and mismatch, 64-bit
    regs[1] = 64'h18; regs[2] = 64'hDEAD_BEEF_0123_4567; regs[0] = mem_m[3];
    do_amo(8'hDB, 1, 2, 16'h0000, 32'hF1);
    regs[0] = 64'h1; do_amo(8'hDB, 1, 2, 16'h0000, 32'hF1);
    // R7: 32-bit compare-and-swap on upper half, negative offset
    regs[3] = 64'h40; regs[4] = 64'hFFFF_FFFF_AAAA_5555; regs[0] = {32'hFFFF_0000, mem_m[6][63:32]};
    do_amo(8'hC3, 3, 4, 16'hFFF4, 32'hF1);
    // R5 exchange 32-bit low half, R4 plain add, R2 upper address bits
    regs[5] = 64'hF000_0000_0000_0020; regs[6] = 64'h1234_5678_9ABC_DEF0;
    do_amo(8'hC3, 5, 6, 16'h0000, 32'hE1);
    do_amo(8'hDB, 5, 6, 16'h0008, 32'h00);
    // R8 corner encodings
    do_amo(8'hDB, 5, 6, 16'h0, 32'hE0);
    do_amo(8'hDB, 5, 6, 16'h0, 32'hF0);
    do_amo(8'hDB, 5, 6, 16'h0, 32'h0100_0001);
    do_amo(8'h7B, 5, 6, 16'h0, 32'h01);
    // R9 misalignment; R8 wins over misalignment
    do_amo(8'hDB, 5, 6, 16'h0004, 32'h01);
    do_amo(8'hC3, 5, 6, 16'h0002, 32'h41);
    do_amo(8'hDB, 5, 6, 16'h0004, 32'h33);

    for (int n = 0; n < 300; n++) begin
      logic [3:0]  d, s;
      logic [7:0]  opc;
      logic [31:0] imm;
      logic [15:0] off;
      logic [63:0] ea, old;
      int step;
      d = 4'($urandom_range(1, 15));
      s = 4'($urandom_range(0, 15));
      if (s == d) s = d ^ 4'h1;
      if (s == 0 && d == 1) s = 4'd2;
      opc = ($urandom % 2) ? 8'hDB : 8'hC3;
      imm = ($urandom % 12 == 0) ? 32'($urandom % 256) : legal[$urandom % 10];
      step = (opc == 8'hC3) ? 4 : 8;
      regs[d] = {$urandom, $urandom} & ~64'h7;
      off = 16'(($urandom_range(0, 40) - 20) * step);
      if ($urandom % 10 == 0) off = off + 16'($urandom_range(1, 3));
      regs[s] = {$urandom, $urandom};
      if (imm[7:0] == 8'hF1 && s != 0) begin
        ea = ea_of(d, off);
        old = mem_m[ea[6:3]];
        regs[0] = {$urandom, $urandom};
        if ($urandom % 2) regs[0] = (opc == 8'hC3) ? {regs[0][63:32], (ea[2] ? old[63:32] : old[31:0])} : old;
      end
      do_amo(opc, d, s, off, imm);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule